// File: doc/BRIEF.md
# Show-Cycle External Bus Gate

This block sits between the internal bus of a microcontroller and its external bus pins. It decides what the pins show while the internal master runs a transfer to an on-chip resource. The address, function code, transfer size and read/write lines always copy the internal bus, in every mode. The data strobe and the data-bus output enable are asserted only when the debug mirroring mode allows it. A two-bit mode register selects one of three behaviours. In the first, internal transfers stay hidden. In the second, they are mirrored onto the external pins so a logic analyser can follow them. The third mirrors them and also stalls the internal bus while an external master holds the bus.

The address strobe comes from the external cycle sequencer. This block suppresses it during any internal cycle, so an external device never decodes a mirrored transfer as its own. While an external master owns the bus, this block drives neither the data strobe nor the data bus.

Top module: `showgate`

## Requirements
- R1: A synchronous active-high reset sets the mode to 00 (hidden). After reset, an internal cycle asserts neither the data strobe nor the output enable, and there is no halt request.
- R2: `ext_addr`, `ext_fc`, `ext_size` and `ext_rw` equal `int_addr`, `int_fc`, `int_size` and `int_rw` in the same cycle, whatever the mode.
- R3: In mode 00, `ext_ds` and `ext_data_oe` stay low during internal cycles, and `ext_data_out` is all zeros.
- R4: In mode 01 or 10, with no external master, an internal cycle raises `ext_ds` and `ext_data_oe` in the same cycle and drives `int_data` on `ext_data_out`. Outside internal cycles, `ext_ds` and `ext_data_oe` are low.
- R5: `ext_as` is never high while `int_cyc` is high. When `int_cyc` is low, `ext_as` follows `seq_as`.
- R6: `int_halt` is high exactly when the mode is 11 and `ext_master` is high. Modes 00, 01 and 10 never request a halt.
- R7: While `ext_master` is high, `ext_ds` and `ext_data_oe` are low in every mode.
- R8: A write through `mode_we`/`mode_wdata` takes effect from the cycle after the clock edge that captures it. With `mode_we` low, the mode holds its value.
- R9: In mode 11 with no external master, internal cycles are mirrored exactly as in modes 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 2 | Mode value to write |
| int_cyc | input | 1 | Internal cycle to an on-chip resource is in progress |
| int_addr | input | ADDR_W | Internal address |
| int_fc | input | FC_W | Internal function code |
| int_size | input | SZ_W | Internal transfer size |
| int_rw | input | 1 | Internal read (1) / write (0) |
| int_data | input | DATA_W | Internal data |
| ext_master | input | 1 | An external master owns the bus |
| seq_as | input | 1 | Address strobe request from the external cycle sequencer |
| ext_addr | output | ADDR_W | External address pins |
| ext_fc | output | FC_W | External function code pins |
| ext_size | output | SZ_W | External size pins |
| ext_rw | output | 1 | External read/write pin |
| ext_as | output | 1 | External address strobe (active high) |
| ext_ds | output | 1 | External data strobe (active high) |
| ext_data_oe | output | 1 | External data bus output enable |
| ext_data_out | output | DATA_W | Data for the external bus |
| int_halt | output | 1 | Request to freeze the internal bus |

## Verification
The mode register is the only state in this block. A wrong mode shows in the first internal cycle after the write or the reset that should have set it. The symptom is a data strobe or output enable that appears where it should be absent, or is missing where it should appear. A wrong mode can also show as a halt request that follows `ext_master` when it should stay low. Each scenario writes a mode, and the next cycle drives internal cycles with and without an external master. A write with the enable low must leave the observed behaviour unchanged.

// File: rtl/showgate_pkg.sv
package showgate_pkg;

    typedef enum logic [1:0] {
        MODE_HIDE        = 2'b00,
        MODE_MIRROR_A    = 2'b01,
        MODE_MIRROR_B    = 2'b10,
        MODE_MIRROR_HALT = 2'b11
    } show_mode_e;

    typedef struct packed {
        logic ds;
        logic oe;
        logic halt;
    } strobe_ctl_t;

    function automatic logic mode_mirrors(show_mode_e m);
        return m != MODE_HIDE;
    endfunction

    function automatic logic mode_halts(show_mode_e m);
        return m == MODE_MIRROR_HALT;
    endfunction

endpackage

// File: rtl/sg_mode_reg.sv
module sg_mode_reg
    import showgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] wdata,
    output show_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_HIDE;
        else if (we)
            mode <= show_mode_e'(wdata);
    end
endmodule

// File: rtl/sg_strobe_ctl.sv
module sg_strobe_ctl
    import showgate_pkg::*;
(
    input  show_mode_e  mode,
    input  logic        int_cyc,
    input  logic        ext_master,
    input  logic        seq_as,
    output strobe_ctl_t ctl,
    output logic        as_out
);
    logic mirror_now;

    always_comb begin
        mirror_now = int_cyc && mode_mirrors(mode) && !ext_master;
        ctl.ds     = mirror_now;
        ctl.oe     = mirror_now;
        ctl.halt   = mode_halts(mode) && ext_master;
        as_out     = seq_as && !int_cyc;
    end
endmodule

// File: rtl/sg_data_drive.sv
module sg_data_drive #(
    parameter int DATA_W = 16
) (
    input  logic              oe,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_comb dout = oe ? din : '0;
endmodule

// File: rtl/showgate.sv
module showgate
    import showgate_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int FC_W   = 3,
    parameter int SZ_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    input  logic              int_cyc,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [FC_W-1:0]   int_fc,
    input  logic [SZ_W-1:0]   int_size,
    input  logic              int_rw,
    input  logic [DATA_W-1:0] int_data,
    input  logic              ext_master,
    input  logic              seq_as,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [FC_W-1:0]   ext_fc,
    output logic [SZ_W-1:0]   ext_size,
    output logic              ext_rw,
    output logic              ext_as,
    output logic              ext_ds,
    output logic              ext_data_oe,
    output logic [DATA_W-1:0] ext_data_out,
    output logic              int_halt
);
    show_mode_e  mode;
    strobe_ctl_t ctl;

    sg_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (mode)
    );

    sg_strobe_ctl u_ctl (
        .mode       (mode),
        .int_cyc    (int_cyc),
        .ext_master (ext_master),
        .seq_as     (seq_as),
        .ctl        (ctl),
        .as_out     (ext_as)
    );

    sg_data_drive #(.DATA_W(DATA_W)) u_data (
        .oe   (ctl.oe),
        .din  (int_data),
        .dout (ext_data_out)
    );

    assign ext_addr    = int_addr;
    assign ext_fc      = int_fc;
    assign ext_size    = int_size;
    assign ext_rw      = int_rw;
    assign ext_ds      = ctl.ds;
    assign ext_data_oe = ctl.oe;
    assign int_halt    = ctl.halt;
endmodule

// File: rtl/showgate_chk.sv
module showgate_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_we,
    input logic [1:0]        mode_wdata,
    input logic              int_cyc,
    input logic [ADDR_W-1:0] int_addr,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_master,
    input logic              ext_as,
    input logic              ext_ds,
    input logic              ext_data_oe,
    input logic [DATA_W-1:0] ext_data_out,
    input logic              int_halt
);
    assert_as_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        int_cyc |-> !ext_as);

    assert_ds_needs_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        ext_ds |-> int_cyc);

    assert_no_drive_ext_R7: assert property (@(posedge clk) disable iff (rst)
        ext_master |-> (!ext_data_oe && !ext_ds));

    assert_halt_needs_ext_R6: assert property (@(posedge clk) disable iff (rst)
        int_halt |-> ext_master);

    assert_addr_follow_R2: assert property (@(posedge clk) disable iff (rst)
        ext_addr == int_addr);

    assert_hidden_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !ext_data_oe |-> (ext_data_out == '0));

    assert_write_hide_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_we && mode_wdata == 2'b00) |=> (!ext_ds && !int_halt));

    assert_write_halt_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_we && mode_wdata == 2'b11) |=> (int_halt == ext_master));

    assert_reset_hide_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(mode_we)) |-> (!ext_ds && !int_halt));
endmodule

bind showgate showgate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_we      (mode_we),
    .mode_wdata   (mode_wdata),
    .int_cyc      (int_cyc),
    .int_addr     (int_addr),
    .ext_addr     (ext_addr),
    .ext_master   (ext_master),
    .ext_as       (ext_as),
    .ext_ds       (ext_ds),
    .ext_data_oe  (ext_data_oe),
    .ext_data_out (ext_data_out),
    .int_halt     (int_halt)
);

// File: tb/sim_showgate.sv
module sim_showgate;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int FC_W   = 3;
    localparam int SZ_W   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_we = 1'b0;
    logic [1:0]        mode_wdata = 2'b00;
    logic              int_cyc = 1'b0;
    logic [ADDR_W-1:0] int_addr = '0;
    logic [FC_W-1:0]   int_fc = '0;
    logic [SZ_W-1:0]   int_size = '0;
    logic              int_rw = 1'b0;
    logic [DATA_W-1:0] int_data = '0;
    logic              ext_master = 1'b0;
    logic              seq_as = 1'b0;
    logic [ADDR_W-1:0] ext_addr;
    logic [FC_W-1:0]   ext_fc;
    logic [SZ_W-1:0]   ext_size;
    logic              ext_rw;
    logic              ext_as;
    logic              ext_ds;
    logic              ext_data_oe;
    logic [DATA_W-1:0] ext_data_out;
    logic              int_halt;

    int checks = 0;
    int errors = 0;
    logic [1:0] bmode = 2'b00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    showgate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W), .SZ_W(SZ_W)) u0 (.*);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_mode(logic [1:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
        bmode = m;
    endtask

    // Drive one internal cycle pattern and check every output against the model
    task automatic cycle_check(string tag, logic cyc, logic xm, logic sas,
                               logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        logic mir;
        @(negedge clk);
        int_cyc = cyc; ext_master = xm; seq_as = sas;
        int_addr = a; int_data = d;
        int_fc = a[2:0]; int_size = a[4:3]; int_rw = a[5];
        #1;
        mir = cyc && (bmode != 2'b00) && !xm;
        check({tag, " R2 addr"}, 64'(ext_addr), 64'(a));
        check({tag, " R2 attr"}, 64'({ext_fc, ext_size, ext_rw}),
              64'({a[2:0], a[4:3], a[5]}));
        check({tag, " R5 as"}, 64'(ext_as), 64'(sas && !cyc));
        check({tag, " ds R3/R4/R7"}, 64'(ext_ds), 64'(mir));
        check({tag, " oe R3/R4/R7"}, 64'(ext_data_oe), 64'(mir));
        check({tag, " data R3/R4"}, 64'(ext_data_out), 64'(mir ? d : '0));
        check({tag, " R6 halt"}, 64'(int_halt), 64'((bmode == 2'b11) && xm));
    endtask

    task automatic t_reset_R1;
        cycle_check("reset R1", 1'b1, 1'b0, 1'b0, 24'h000123, 16'hBEEF);
        cycle_check("reset R1 xm", 1'b1, 1'b1, 1'b0, 24'h000456, 16'h1234);
    endtask

    task automatic t_hidden_R3;
        write_mode(2'b00);
        cycle_check("hide R3", 1'b1, 1'b0, 1'b1, 24'hABCDEF, 16'h5A5A);
        cycle_check("hide R3 idle", 1'b0, 1'b0, 1'b1, 24'h123456, 16'hFFFF);
    endtask

    task automatic t_mirror_R4;
        write_mode(2'b01);
        cycle_check("mirA R4", 1'b1, 1'b0, 1'b1, 24'h00F00D, 16'hC0DE);
        cycle_check("mirA R4 idle", 1'b0, 1'b0, 1'b1, 24'h00F00E, 16'hC0DF);
        write_mode(2'b10);
        cycle_check("mirB R4", 1'b1, 1'b0, 1'b0, 24'hFFFFFF, 16'hFFFF);
        cycle_check("mirB R7", 1'b1, 1'b1, 1'b0, 24'h000001, 16'h0001);
    endtask

    task automatic t_halt_R6_R9;
        write_mode(2'b11);
        cycle_check("halt R9", 1'b1, 1'b0, 1'b0, 24'h0A0A0A, 16'hA5A5);
        cycle_check("halt R6 xm", 1'b0, 1'b1, 1'b1, 24'h0B0B0B, 16'h5A5A);
        cycle_check("halt R7 cyc", 1'b1, 1'b1, 1'b0, 24'h0C0C0C, 16'h7777);
        write_mode(2'b01);
        cycle_check("mirA R6 nohalt", 1'b0, 1'b1, 1'b0, 24'h0D0D0D, 16'h1111);
    endtask

    task automatic t_write_timing_R8;
        write_mode(2'b00);
        @(negedge clk);
        int_cyc = 1'b1; ext_master = 1'b0; int_data = 16'h4242;
        mode_we = 1'b1; mode_wdata = 2'b01;
        #1;
        check("R8 before edge", 64'(ext_ds), 64'(0));
        @(negedge clk);
        mode_we = 1'b0; bmode = 2'b01;
        #1;
        check("R8 after edge", 64'(ext_ds), 64'(1));
        check("R8 after edge data", 64'(ext_data_out), 64'(16'h4242));
        // Data present with enable low must not change the mode
        @(negedge clk);
        mode_wdata = 2'b00;
        @(negedge clk);
        cycle_check("R8 hold", 1'b1, 1'b0, 1'b0, 24'h777777, 16'h9999);
    endtask

    task automatic t_reset_again_R1;
        write_mode(2'b11);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; bmode = 2'b00;
        cycle_check("rereset R1", 1'b1, 1'b0, 1'b0, 24'h313131, 16'h3131);
        cycle_check("rereset R1 xm", 1'b0, 1'b1, 1'b0, 24'h323232, 16'h3232);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_R1();
        t_hidden_R3();
        t_mirror_R4();
        t_halt_R6_R9();
        t_write_timing_R8();
        t_reset_again_R1();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule